// File: doc/BRIEF.md
# Transactional victim cache controller

This block is a small direct-mapped store that sits behind a set-associative L1 data cache. Its only job is to hold transactional lines that L1 throws out because of set conflicts, so that a running transaction does not have to fall back to serial execution just because one L1 set filled up. Any other eviction, and any line that cannot be placed, is handed straight on to the memory write port. When a line is refilled from this store back into L1, it leaves the store. The L1 line that gets displaced by that refill comes back in later through the ordinary eviction input.

The store is powered off when idle. The first transactional victim of a transaction wakes it up, and the CPU is stalled for a fixed number of cycles while that happens. If a transactional victim maps onto a slot that already holds a different transactional line, the block raises a sticky request to switch to serial mode. That victim is then forwarded to memory.

When a transaction commits, the block stalls the CPU and walks its slots in ascending index order. It writes each dirty line to memory, one per memory handshake, and then clears itself and powers down. An abort discards every line without writing anything, because no backup copies are kept. Probing L1 first is the job of the surrounding cache: the lookup port is only driven after an L1 miss.

Top module: `tx_victim_cache`

## Requirements
- R1: After reset the store is unpowered. `vcPowered`, `cpuStall`, `ovfReq` and `memValid` are all low, and a lookup reports a miss.
- R2: An eviction that is not both transactional (`evTx`=1) and conflict-caused (`evConflict`=1) is never stored. It appears on the memory port with the same address and data, `evReady` follows `memReady`, and a later lookup of that address misses.
- R3: A transactional conflict victim is captured into slot `evAddr[IDX_W-1:0]` when that slot is empty or holds the same address. It is accepted with no memory write, and a lookup of its address while powered reports a hit with the stored data in the same cycle.
- R4: A capturable victim that arrives while the store is unpowered starts a wake. `vcPowered` rises, and `cpuStall` stays high with `evReady` low for exactly WAKE_CYC cycles. After that the victim is accepted.
- R5: A transactional conflict victim whose slot holds a different valid address sets `ovfReq`. `ovfReq` stays set until the transaction ends or aborts. The victim goes to the memory port, and the resident line stays in place.
- R6: A lookup hit removes the line from the store, so a second lookup of the same address misses.
- R7: When a lookup hit and a capture target the same slot in the same cycle, the slot counts as free. The capture is accepted, no overflow is raised, and the new line is the one that stays.
- R8: After a `txEnd` pulse while powered, `cpuStall` stays high for N_LINES cycles when the memory is always ready. Only valid dirty lines are written, in ascending slot order. After that, the store is empty, unpowered, and `ovfReq` is clear.
- R9: A `txAbort` pulse empties the store, writes nothing to memory, powers down and clears `ovfReq`.
- R10: A `txEnd` pulse while unpowered causes no stall and no memory write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evValid | input | 1 | L1 presents an evicted line |
| evReady | output | 1 | Eviction accepted this cycle |
| evAddr | input | LA_W | Line address of the evicted line |
| evData | input | LINE_W | Evicted line contents |
| evDirty | input | 1 | Evicted line is modified |
| evTx | input | 1 | Evicted line belongs to the running transaction |
| evConflict | input | 1 | Eviction was caused by a set conflict |
| lkValid | input | 1 | Lookup after an L1 miss |
| lkAddr | input | LA_W | Lookup line address |
| lkHit | output | 1 | Lookup found the line; it is handed to L1 and removed |
| lkData | output | LINE_W | Contents of the hit line |
| memValid | output | 1 | Line write to memory offered |
| memReady | input | 1 | Memory takes the offered write |
| memAddr | output | LA_W | Line address of the memory write |
| memData | output | LINE_W | Line contents of the memory write |
| txEnd | input | 1 | Transaction commit pulse |
| txAbort | input | 1 | Transaction abort pulse |
| vcPowered | output | 1 | Store is powered (waking, active or flushing) |
| cpuStall | output | 1 | CPU must stall (wake or commit flush) |
| ovfReq | output | 1 | Request to continue in serial mode |

## Verification
A lookup hit and a capture can land on the same slot in the same cycle. The lookup frees the slot just as the new victim asks for it, so a design that judges the slot by its pre-edge contents would raise a false overflow. The bench fills a slot, then drives a lookup of that line together with an eviction of a different address that maps to the same slot. It checks that the hit data is returned and the eviction is accepted in that same cycle, that `ovfReq` stays low, and that a later lookup finds the new line rather than the old one.

// File: rtl/txvc_pkg.sv
package txvc_pkg;
  typedef enum logic [1:0] {VC_OFF, VC_WAKE, VC_ON, VC_FLUSH} vc_state_e;

  typedef struct packed {
    logic capture;
    logic consume;
    logic clearAll;
    logic flushStart;
    logic flushStep;
    logic flushMode;
  } vc_strobe_t;
endpackage

// File: rtl/txvc_data.sv
module txvc_data
  import txvc_pkg::*;
#(
  parameter int LA_W    = 16,
  parameter int LINE_W  = 32,
  parameter int N_LINES = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  vc_strobe_t        strb,
  input  logic [LA_W-1:0]   evAddr,
  input  logic [LINE_W-1:0] evData,
  input  logic              evDirty,
  input  logic [LA_W-1:0]   lkAddr,
  output logic              hitRaw,
  output logic              evBlocked,
  output logic [LINE_W-1:0] lkData,
  output logic              flushDirty,
  output logic              flushLast,
  output logic [LA_W-1:0]   memAddr,
  output logic [LINE_W-1:0] memData
);
  localparam int IDX_W = $clog2(N_LINES);
  localparam int TAG_W = LA_W - IDX_W;

  logic [N_LINES-1:0] validQ;
  logic [N_LINES-1:0] dirtyQ;
  logic [TAG_W-1:0]   tagQ  [N_LINES];
  logic [LINE_W-1:0]  dataQ [N_LINES];
  logic [IDX_W-1:0]   flushIdxQ;

  logic [IDX_W-1:0] evIdx, lkIdx;
  logic [TAG_W-1:0] evTag, lkTag;
  logic [N_LINES-1:0] wrEn, invEn;

  assign evIdx = evAddr[IDX_W-1:0];
  assign evTag = evAddr[LA_W-1:IDX_W];
  assign lkIdx = lkAddr[IDX_W-1:0];
  assign lkTag = lkAddr[LA_W-1:IDX_W];

  // Per-slot write and invalidate enables
  genvar g;
  generate
    for (g = 0; g < N_LINES; g++) begin : g_slot
      assign wrEn[g]  = strb.capture && (evIdx == IDX_W'(g));
      assign invEn[g] = strb.consume && (lkIdx == IDX_W'(g));
    end
  endgenerate

  assign hitRaw = validQ[lkIdx] && (tagQ[lkIdx] == lkTag);
  assign lkData = dataQ[lkIdx];

  // A slot being handed back to L1 this cycle counts as free for a new victim
  assign evBlocked = validQ[evIdx] && (tagQ[evIdx] != evTag) &&
                     !(strb.consume && (lkIdx == evIdx));

  assign flushDirty = validQ[flushIdxQ] && dirtyQ[flushIdxQ];
  assign flushLast  = (flushIdxQ == IDX_W'(N_LINES - 1));

  assign memAddr = strb.flushMode ? {tagQ[flushIdxQ], flushIdxQ} : evAddr;
  assign memData = strb.flushMode ? dataQ[flushIdxQ] : evData;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ <= '0;
      dirtyQ <= '0;
    end else if (strb.clearAll) begin
      validQ <= '0;
      dirtyQ <= '0;
    end else begin
      for (int i = 0; i < N_LINES; i++) begin
        if (wrEn[i]) begin
          validQ[i] <= 1'b1;
          dirtyQ[i] <= evDirty;
        end else if (invEn[i]) begin
          validQ[i] <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < N_LINES; i++) begin
      if (wrEn[i]) begin
        tagQ[i]  <= evTag;
        dataQ[i] <= evData;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                flushIdxQ <= '0;
    else if (strb.flushStart) flushIdxQ <= '0;
    else if (strb.flushStep)  flushIdxQ <= flushIdxQ + 1'b1;
  end

  // R9: a clear leaves no line behind
  p_clear_empties_r9: assert property (@(posedge clk) disable iff (!rstN)
    strb.clearAll |=> (validQ == '0));

  // R3: a captured victim is resident in its slot next cycle
  p_capture_resident_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture && !strb.clearAll |=> validQ[$past(evIdx)]);

  // R6: a consumed line is gone unless the same slot was refilled
  p_consume_frees_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.consume && !(strb.capture && evIdx == lkIdx) |=> !validQ[$past(lkIdx)]);

  // R8: the flush walk advances one slot per step
  p_flush_walk_r8: assert property (@(posedge clk) disable iff (!rstN)
    strb.flushStep && !flushLast |=> strb.flushMode && (flushIdxQ != '0));
endmodule

// File: rtl/txvc_ctrl.sv
module txvc_ctrl
  import txvc_pkg::*;
#(
  parameter int WAKE_CYC = 40
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       evValid,
  input  logic       evTx,
  input  logic       evConflict,
  input  logic       lkValid,
  input  logic       memReady,
  input  logic       txEnd,
  input  logic       txAbort,
  input  logic       hitRaw,
  input  logic       evBlocked,
  input  logic       flushDirty,
  input  logic       flushLast,
  output vc_strobe_t strb,
  output logic       evReady,
  output logic       memValid,
  output logic       lkHit,
  output logic       vcPowered,
  output logic       cpuStall,
  output logic       ovfReq
);
  localparam int CNT_W = (WAKE_CYC > 1) ? $clog2(WAKE_CYC) : 1;

  vc_state_e        stateQ;
  logic [CNT_W-1:0] wakeCntQ;
  logic             ovfQ;

  logic ending, eligible, isOn, doCap, doPass, ovfSet, flushDone;

  assign ending   = txEnd || txAbort;
  assign eligible = evTx && evConflict;
  assign isOn     = (stateQ == VC_ON);

  always_comb begin
    doCap  = 1'b0;
    doPass = 1'b0;
    if (!ending && stateQ != VC_FLUSH) begin
      if (eligible) begin
        if (isOn) begin
          if (evBlocked) doPass = 1'b1;
          else           doCap  = 1'b1;
        end
      end else begin
        doPass = 1'b1;
      end
    end
  end

  assign lkHit     = lkValid && isOn && !ending && hitRaw;
  assign evReady   = doCap || (doPass && memReady);
  assign memValid  = (stateQ == VC_FLUSH) ? (flushDirty && !txAbort) : (doPass && evValid);
  assign ovfSet    = doPass && eligible && evValid && memReady;
  assign flushDone = strb.flushStep && flushLast;

  always_comb begin
    strb            = '0;
    strb.capture    = doCap && evValid;
    strb.consume    = lkHit;
    strb.flushMode  = (stateQ == VC_FLUSH);
    strb.flushStep  = (stateQ == VC_FLUSH) && !txAbort && (!flushDirty || memReady);
    strb.flushStart = isOn && txEnd && !txAbort;
    strb.clearAll   = txAbort || ((stateQ == VC_FLUSH) && !txAbort && (!flushDirty || memReady) && flushLast) ||
                      ((stateQ == VC_WAKE) && txEnd);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ   <= VC_OFF;
      wakeCntQ <= '0;
    end else begin
      unique case (stateQ)
        VC_OFF: if (evValid && eligible && !ending) begin
          stateQ   <= VC_WAKE;
          wakeCntQ <= '0;
        end
        VC_WAKE: begin
          if (ending)                                stateQ <= VC_OFF;
          else if (wakeCntQ == CNT_W'(WAKE_CYC - 1)) stateQ <= VC_ON;
          else                                       wakeCntQ <= wakeCntQ + 1'b1;
        end
        VC_ON: begin
          if (txAbort)    stateQ <= VC_OFF;
          else if (txEnd) stateQ <= VC_FLUSH;
        end
        VC_FLUSH: if (txAbort || flushDone) stateQ <= VC_OFF;
        default: stateQ <= VC_OFF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                     ovfQ <= 1'b0;
    else if (txAbort || flushDone) ovfQ <= 1'b0;
    else if (ovfSet)               ovfQ <= 1'b1;
  end

  assign ovfReq    = ovfQ;
  assign vcPowered = (stateQ != VC_OFF);
  assign cpuStall  = (stateQ == VC_WAKE) || (stateQ == VC_FLUSH);

  // R3: capture happens only in the active, unstalled state
  p_capture_active_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |-> vcPowered && !cpuStall);

  // R4: power comes up together with the wake stall
  p_wake_stalls_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(vcPowered) |-> cpuStall && !evReady);

  // R5: overflow request holds until commit completes or abort
  p_ovf_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    ovfReq && !txAbort && !flushDone |=> ovfReq);

  // R10: an unpowered store never requests serial mode
  p_off_no_ovf_r10: assert property (@(posedge clk) disable iff (!rstN)
    !vcPowered |-> !ovfReq);

  // R8: a stalled flush write stays offered
  p_flush_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == VC_FLUSH) && memValid && !memReady && !txAbort |=> memValid && (stateQ == VC_FLUSH));

  // R6: no lookup can hit while the CPU is stalled
  p_stall_no_hit_r6: assert property (@(posedge clk) disable iff (!rstN)
    cpuStall |-> !lkHit);
endmodule

// File: rtl/tx_victim_cache.sv
module tx_victim_cache
  import txvc_pkg::*;
#(
  parameter int LA_W     = 16,
  parameter int LINE_W   = 32,
  parameter int N_LINES  = 8,
  parameter int WAKE_CYC = 40
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              evValid,
  output logic              evReady,
  input  logic [LA_W-1:0]   evAddr,
  input  logic [LINE_W-1:0] evData,
  input  logic              evDirty,
  input  logic              evTx,
  input  logic              evConflict,
  input  logic              lkValid,
  input  logic [LA_W-1:0]   lkAddr,
  output logic              lkHit,
  output logic [LINE_W-1:0] lkData,
  output logic              memValid,
  input  logic              memReady,
  output logic [LA_W-1:0]   memAddr,
  output logic [LINE_W-1:0] memData,
  input  logic              txEnd,
  input  logic              txAbort,
  output logic              vcPowered,
  output logic              cpuStall,
  output logic              ovfReq
);
  vc_strobe_t strb;
  logic hitRaw, evBlocked, flushDirty, flushLast;

  txvc_ctrl #(.WAKE_CYC(WAKE_CYC)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .evValid(evValid), .evTx(evTx), .evConflict(evConflict),
    .lkValid(lkValid), .memReady(memReady),
    .txEnd(txEnd), .txAbort(txAbort),
    .hitRaw(hitRaw), .evBlocked(evBlocked),
    .flushDirty(flushDirty), .flushLast(flushLast),
    .strb(strb), .evReady(evReady), .memValid(memValid), .lkHit(lkHit),
    .vcPowered(vcPowered), .cpuStall(cpuStall), .ovfReq(ovfReq)
  );

  txvc_data #(.LA_W(LA_W), .LINE_W(LINE_W), .N_LINES(N_LINES)) u_data (
    .clk(clk), .rstN(rstN), .strb(strb),
    .evAddr(evAddr), .evData(evData), .evDirty(evDirty),
    .lkAddr(lkAddr),
    .hitRaw(hitRaw), .evBlocked(evBlocked), .lkData(lkData),
    .flushDirty(flushDirty), .flushLast(flushLast),
    .memAddr(memAddr), .memData(memData)
  );
endmodule

// File: tb/sim_tx_victim_cache.sv
module sim_tx_victim_cache;
  localparam int LA_W = 16, LINE_W = 32, N_LINES = 8, WAKE_CYC = 40;

  logic clk = 1'b0, rstN = 1'b0;
  logic evValid = 0, evDirty = 0, evTx = 0, evConflict = 0, lkValid = 0;
  logic memReady = 1, txEnd = 0, txAbort = 0;
  logic [LA_W-1:0] evAddr = '0, lkAddr = '0;
  logic [LINE_W-1:0] evData = '0;
  logic evReady, lkHit, memValid, vcPowered, cpuStall, ovfReq;
  logic [LINE_W-1:0] lkData, memData;
  logic [LA_W-1:0] memAddr;

  int nChecks = 0, nFails = 0, memCnt = 0;
  logic [LA_W-1:0]   logAddr [64];
  logic [LINE_W-1:0] logData [64];

  always #2 clk = ~clk;

  tx_victim_cache #(.LA_W(LA_W), .LINE_W(LINE_W), .N_LINES(N_LINES), .WAKE_CYC(WAKE_CYC)) u0 (
    .clk(clk), .rstN(rstN), .evValid(evValid), .evReady(evReady), .evAddr(evAddr),
    .evData(evData), .evDirty(evDirty), .evTx(evTx), .evConflict(evConflict),
    .lkValid(lkValid), .lkAddr(lkAddr), .lkHit(lkHit), .lkData(lkData),
    .memValid(memValid), .memReady(memReady), .memAddr(memAddr), .memData(memData),
    .txEnd(txEnd), .txAbort(txAbort), .vcPowered(vcPowered), .cpuStall(cpuStall), .ovfReq(ovfReq)
  );

  always @(posedge clk) begin
    if (rstN && memValid && memReady && memCnt < 64) begin
      logAddr[memCnt] = memAddr;
      logData[memCnt] = memData;
      memCnt = memCnt + 1;
    end
  end

  // addr[15:0], tx, conflict, dirty, expect (0 capture, 1 forward, 2 overflow)
  localparam int NV = 8;
  localparam logic [20:0] EVTBL [NV] = '{
    {16'h0010, 1'b1, 1'b1, 1'b1, 2'd0},
    {16'h0021, 1'b1, 1'b1, 1'b0, 2'd0},
    {16'h0032, 1'b0, 1'b1, 1'b1, 2'd1},
    {16'h0043, 1'b1, 1'b0, 1'b1, 2'd1},
    {16'h0018, 1'b1, 1'b1, 1'b1, 2'd2},
    {16'h0010, 1'b1, 1'b1, 1'b1, 2'd0},
    {16'h0025, 1'b1, 1'b1, 1'b1, 2'd0},
    {16'h0026, 1'b1, 1'b1, 1'b0, 2'd0}
  };

  function automatic logic [LINE_W-1:0] fdat(input logic [LA_W-1:0] a, input int i);
    return {8'hA0 + i[7:0], 8'h5C, a};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic sendEv(input logic [LA_W-1:0] a, input logic [LINE_W-1:0] d,
                        input logic tx, input logic cf, input logic dy, output int stalls);
    stalls = 0;
    @(negedge clk);
    evValid = 1; evAddr = a; evData = d; evTx = tx; evConflict = cf; evDirty = dy;
    #1;
    while (!evReady) begin
      @(negedge clk); #1;
      if (cpuStall) stalls++;
    end
    @(posedge clk); #1;
    evValid = 0;
  endtask

  task automatic lookup(input logic [LA_W-1:0] a, output logic hit, output logic [LINE_W-1:0] d);
    @(negedge clk);
    lkValid = 1; lkAddr = a;
    #1; hit = lkHit; d = lkData;
    @(posedge clk); #1;
    lkValid = 0;
  endtask

  task automatic pulseEnd(input bit abort);
    @(negedge clk);
    if (abort) txAbort = 1; else txEnd = 1;
    @(posedge clk); #1;
    txAbort = 0; txEnd = 0;
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    logic hit;
    logic [LINE_W-1:0] d;
    int st, base, cnt;
    bit ovfExp;

    repeat (3) @(posedge clk);
    #1 rstN = 1;

    // R1: reset state
    @(negedge clk); #1;
    chk(!vcPowered && !cpuStall && !ovfReq && !memValid, "R1", "idle outputs",
        {vcPowered, cpuStall, ovfReq, memValid}, 0);
    lookup(16'h0010, hit, d);
    chk(!hit, "R1", "lookup while off", hit, 0);

    // Table walk: R2 R3 R4 R5
    ovfExp = 0;
    for (int i = 0; i < NV; i++) begin
      base = memCnt;
      sendEv(EVTBL[i][20:5], fdat(EVTBL[i][20:5], i), EVTBL[i][4], EVTBL[i][3], EVTBL[i][2], st);
      if (i == 0) chk(st == WAKE_CYC, "R4", "wake stall cycles", st, WAKE_CYC);
      if (EVTBL[i][1:0] == 2'd0) begin
        chk(memCnt == base, "R3", "capture writes nothing", memCnt - base, 0);
      end else begin
        chk(memCnt == base + 1 && logAddr[base] == EVTBL[i][20:5] &&
            logData[base] == fdat(EVTBL[i][20:5], i), "R2", "forwarded line",
            logAddr[base], EVTBL[i][20:5]);
      end
      if (EVTBL[i][1:0] == 2'd2) ovfExp = 1;
      @(negedge clk); #1;
      chk(ovfReq == ovfExp, "R5", "overflow request", ovfReq, ovfExp);
    end

    lookup(16'h0021, hit, d);
    chk(hit && d == fdat(16'h0021, 1), "R3", "hit data", d, fdat(16'h0021, 1));
    lookup(16'h0021, hit, d);
    chk(!hit, "R6", "second lookup after hit", hit, 0);
    lookup(16'h0032, hit, d);
    chk(!hit, "R2", "forwarded line not stored", hit, 0);
    lookup(16'h0018, hit, d);
    chk(!hit, "R5", "overflowed victim not stored", hit, 0);

    // R8: commit flush
    base = memCnt;
    pulseEnd(0);
    cnt = 0;
    @(negedge clk); #1;
    while (cpuStall && cnt < 100) begin cnt++; @(negedge clk); #1; end
    chk(cnt == N_LINES, "R8", "flush stall cycles", cnt, N_LINES);
    chk(memCnt == base + 2, "R8", "dirty line count", memCnt - base, 2);
    chk(logAddr[base] == 16'h0010 && logData[base] == fdat(16'h0010, 5), "R8", "first write slot 0",
        logAddr[base], 16'h0010);
    chk(logAddr[base+1] == 16'h0025 && logData[base+1] == fdat(16'h0025, 6), "R8", "second write slot 5",
        logAddr[base+1], 16'h0025);
    chk(!vcPowered && !ovfReq, "R8", "off and overflow clear", {vcPowered, ovfReq}, 0);

    // R7: simultaneous hit and capture on slot 3
    sendEv(16'h0033, fdat(16'h0033, 10), 1, 1, 1, st);
    chk(st == WAKE_CYC, "R4", "second wake stall", st, WAKE_CYC);
    @(negedge clk);
    lkValid = 1; lkAddr = 16'h0033;
    evValid = 1; evAddr = 16'h003B; evData = fdat(16'h003B, 11); evTx = 1; evConflict = 1; evDirty = 1;
    #1;
    chk(lkHit && lkData == fdat(16'h0033, 10), "R7", "hit in shared cycle", lkData, fdat(16'h0033, 10));
    chk(evReady, "R7", "capture accepted in shared cycle", evReady, 1);
    @(posedge clk); #1;
    lkValid = 0; evValid = 0;
    @(negedge clk); #1;
    chk(!ovfReq, "R7", "no overflow", ovfReq, 0);
    lookup(16'h003B, hit, d);
    chk(hit && d == fdat(16'h003B, 11), "R7", "new line resident", d, fdat(16'h003B, 11));

    // R9: abort discards
    sendEv(16'h0014, fdat(16'h0014, 12), 1, 1, 1, st);
    sendEv(16'h001C, fdat(16'h001C, 13), 1, 1, 1, st);
    @(negedge clk); #1;
    chk(ovfReq, "R5", "overflow before abort", ovfReq, 1);
    base = memCnt;
    pulseEnd(1);
    repeat (3) @(negedge clk);
    #1;
    chk(memCnt == base, "R9", "abort writes nothing", memCnt - base, 0);
    chk(!vcPowered && !ovfReq && !cpuStall, "R9", "abort power and overflow",
        {vcPowered, ovfReq, cpuStall}, 0);
    lookup(16'h0014, hit, d);
    chk(!hit, "R9", "line discarded", hit, 0);

    // R10: commit while unpowered
    base = memCnt;
    pulseEnd(0);
    cnt = 0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); #1;
      if (cpuStall) cnt++;
    end
    chk(cnt == 0, "R10", "no stall when off", cnt, 0);
    chk(memCnt == base && !vcPowered, "R10", "no writes when off", memCnt - base, 0);

    report();
  end
endmodule